// File: doc/BRIEF.md
# Printer Strobe and Port Merge Controller

This block sits beside the two general-purpose I/O ports of a sound generator and turns their contents into printer and system signals. It keeps its own copy of both port registers, updated by a single write interface that selects port A or port B. Each write to port A is compared with the strobe bit of the previous port A write. When that bit goes from high to low, the port B byte is handed to the printer side, together with a one-cycle interrupt pulse on a busy line and, when the alternate machine mode is set, on an acknowledge line.

Port A also carries two active-low drive selects, which the block decodes into two indicator outputs. On the read side the block merges parallel-port joystick inputs into the returned byte. Up to two joysticks can be enabled, each inverted before it is placed into a nibble of port B. The fire button of the second joystick is reflected in the port A strobe position.

The printer byte leaves on a valid-only stream: `prn_valid` is high for exactly one cycle per transfer and `prn_data` holds that byte until the next transfer. There is no ready input and therefore no back-pressure. The consumer must take the byte in the cycle in which `prn_valid` is high.

Top module: `lpt_strobe_ctrl`

## Requirements
- R1: While and after reset, with no writes: `prn_valid`, `busy_irq` and `ack_irq` are 0, `prn_data` is 0x00, port A holds 0xFF (both indicators off), port B holds 0x00, and the remembered strobe is 0.
- R2: A port A write (`wr_sel`=0) with bit 5 at 0, following a port A write with bit 5 at 1, while `print_en` is 1, gives `prn_valid`=1 and `busy_irq`=1 for exactly the one cycle after the write edge. `prn_data` then equals the port B value held at that write.
- R3: No transfer occurs for a port A write whose strobe stays high, stays low or rises, nor for any port B write (`wr_sel`=1).
- R4: `ack_irq` pulses together with `busy_irq` when `alt_mode` is 1 and stays 0 when `alt_mode` is 0.
- R5: With `print_en` at 0, a falling strobe gives no pulse on any output, but the remembered strobe still follows every port A write.
- R6: The first port A write after reset with bit 5 at 0 causes no transfer, because the remembered strobe resets to 0.
- R7: `prn_data` keeps its value in every cycle without a transfer.
- R8: `drv_a_led` is the inverse of port A bit 1 and `drv_b_led` is the inverse of port A bit 2.
- R9: When `joy1_en` is 1, a port B read (`rd_sel`=1) returns the inverted `joy1_bits` in bits 7:4. When `joy1_en` is 0, those bits come from the stored port B.
- R10: When `joy2_en` is 1, a port B read returns the inverted `joy2_bits` in bits 3:0. When `joy2_en` is 0, those bits come from the stored port B.
- R11: When `joy2_en` is 1, a port A read (`rd_sel`=0) returns bit 5 as 0 while `joy2_fire` is 1 and as 1 while it is 0. The other bits come from the stored port A.
- R12: With both joysticks disabled, `rd_data` equals the stored register selected by `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Port register write strobe |
| wr_sel | input | 1 | Write target: 0 port A, 1 port B |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 port A, 1 port B |
| rd_data | output | 8 | Merged read value (combinational) |
| print_en | input | 1 | Enables printer transfers |
| alt_mode | input | 1 | Adds the acknowledge pulse |
| joy1_en | input | 1 | First joystick present |
| joy1_bits | input | 4 | First joystick lines |
| joy2_en | input | 1 | Second joystick present |
| joy2_bits | input | 4 | Second joystick lines |
| joy2_fire | input | 1 | Second joystick fire, 1 = pressed |
| prn_data | output | 8 | Printer byte |
| prn_valid | output | 1 | One-cycle transfer pulse |
| busy_irq | output | 1 | Busy interrupt pulse |
| ack_irq | output | 1 | Acknowledge interrupt pulse |
| drv_a_led | output | 1 | Drive A indicator |
| drv_b_led | output | 1 | Drive B indicator |

## Verification
The strobe detector is driven with directed sequences that hold bit 5 high, hold it low, raise it, drop it, and interleave port B writes. Together they separate true falling-edge detection from level or rising detection. Separate directed runs toggle `print_en` around a fall, which shows that the strobe history keeps moving while output is gated, and toggle `alt_mode`, which separates the busy pulse from the acknowledge pulse. A long random run mixes writes, idle cycles, joystick enables and read selects, and compares every output against a bench model each cycle, so that wrong nibble placement or a missing inversion shows up under many data values.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  parameter int unsigned LPT_W     = 8;
  parameter int unsigned STB_BIT   = 5;
  parameter int unsigned DRV_A_BIT = 1;
  parameter int unsigned DRV_B_BIT = 2;
  localparam int unsigned NIB_W    = LPT_W / 2;
  localparam logic [LPT_W-1:0] PORT_A_RST = '1;
  localparam logic [LPT_W-1:0] PORT_B_RST = '0;

  typedef enum logic { SEL_A = 1'b0, SEL_B = 1'b1 } port_sel_e;
endpackage

// File: rtl/lpt_port_regs.sv
module lpt_port_regs
  import lpt_pkg::*;
#(
  parameter int unsigned W   = LPT_W,
  parameter int unsigned STB = STB_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] port_a,
  output logic [W-1:0] port_b,
  output logic         strobe_prev,
  output logic         a_write
);
  assign a_write = wr_en && (wr_sel == SEL_A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_a      <= PORT_A_RST[W-1:0];
      port_b      <= PORT_B_RST[W-1:0];
      strobe_prev <= 1'b0;
    end else if (wr_en) begin
      if (wr_sel == SEL_A) begin
        port_a      <= wr_data;
        strobe_prev <= wr_data[STB];
      end else begin
        port_b      <= wr_data;
      end
    end
  end

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_A) |=> (strobe_prev == $past(wr_data[STB]))); // R5

  AST_B_WRITE_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_B) |=> $stable(port_a)); // R3
endmodule

// File: rtl/lpt_edge_xfer.sv
module lpt_edge_xfer
  import lpt_pkg::*;
#(
  parameter int unsigned W = LPT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_write,
  input  logic         new_strobe,
  input  logic         strobe_prev,
  input  logic         print_en,
  input  logic         alt_mode,
  input  logic [W-1:0] port_b,
  output logic [W-1:0] prn_data,
  output logic         prn_valid,
  output logic         busy_irq,
  output logic         ack_irq
);
  logic fall_hit;
  assign fall_hit = a_write && strobe_prev && !new_strobe && print_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prn_data  <= '0;
      prn_valid <= 1'b0;
      busy_irq  <= 1'b0;
      ack_irq   <= 1'b0;
    end else begin
      prn_valid <= fall_hit;
      busy_irq  <= fall_hit;
      ack_irq   <= fall_hit && alt_mode;
      if (fall_hit) prn_data <= port_b;
    end
  end

  AST_FIRE_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    prn_valid |-> $past(a_write && strobe_prev && !new_strobe && print_en)); // R2

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    prn_valid |=> !prn_valid); // R2

  AST_ACK_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_irq |-> busy_irq); // R4

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !prn_valid |-> $stable(prn_data)); // R7
endmodule

// File: rtl/lpt_read_merge.sv
module lpt_read_merge
  import lpt_pkg::*;
#(
  parameter int unsigned W   = LPT_W,
  parameter int unsigned STB = STB_BIT
) (
  input  logic         rd_sel,
  input  logic [W-1:0] port_a,
  input  logic [W-1:0] port_b,
  input  logic         joy1_en,
  input  logic [W/2-1:0] joy1_bits,
  input  logic         joy2_en,
  input  logic [W/2-1:0] joy2_bits,
  input  logic         joy2_fire,
  output logic [W-1:0] rd_data
);
  localparam int unsigned NW = W / 2;

  logic [1:0]         lane_en;
  logic [1:0][NW-1:0] lane_joy;
  logic [W-1:0]       b_merged;
  logic [W-1:0]       a_merged;

  // lane 0 = low nibble (second joystick), lane 1 = high nibble (first)
  assign lane_en  = {joy1_en, joy2_en};
  assign lane_joy = {joy1_bits, joy2_bits};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign b_merged[g*NW +: NW] = lane_en[g] ? ~lane_joy[g]
                                             : port_b[g*NW +: NW];
  end

  always_comb begin
    a_merged = port_a;
    if (joy2_en) a_merged[STB] = ~joy2_fire;
  end

  assign rd_data = (rd_sel == SEL_B) ? b_merged : a_merged;

  always_comb begin
    if (rd_sel == SEL_A && joy2_en)
      AST_FIRE_READ: assert (rd_data[STB] != joy2_fire); // R11
  end
endmodule

// File: rtl/lpt_strobe_ctrl.sv
module lpt_strobe_ctrl
  import lpt_pkg::*;
#(
  parameter int unsigned W = LPT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  input  logic         print_en,
  input  logic         alt_mode,
  input  logic         joy1_en,
  input  logic [W/2-1:0] joy1_bits,
  input  logic         joy2_en,
  input  logic [W/2-1:0] joy2_bits,
  input  logic         joy2_fire,
  output logic [W-1:0] prn_data,
  output logic         prn_valid,
  output logic         busy_irq,
  output logic         ack_irq,
  output logic         drv_a_led,
  output logic         drv_b_led
);
  logic [W-1:0] port_a;
  logic [W-1:0] port_b;
  logic         strobe_prev;
  logic         a_write;

  lpt_port_regs #(.W(W), .STB(STB_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .port_a(port_a), .port_b(port_b),
    .strobe_prev(strobe_prev), .a_write(a_write)
  );

  lpt_edge_xfer #(.W(W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .a_write(a_write),
    .new_strobe(wr_data[STB_BIT]), .strobe_prev(strobe_prev),
    .print_en(print_en), .alt_mode(alt_mode), .port_b(port_b),
    .prn_data(prn_data), .prn_valid(prn_valid),
    .busy_irq(busy_irq), .ack_irq(ack_irq)
  );

  lpt_read_merge #(.W(W), .STB(STB_BIT)) u_merge (
    .rd_sel(rd_sel), .port_a(port_a), .port_b(port_b),
    .joy1_en(joy1_en), .joy1_bits(joy1_bits),
    .joy2_en(joy2_en), .joy2_bits(joy2_bits), .joy2_fire(joy2_fire),
    .rd_data(rd_data)
  );

  assign drv_a_led = ~port_a[DRV_A_BIT];
  assign drv_b_led = ~port_a[DRV_B_BIT];

  AST_NO_ACK_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_irq && !$past(alt_mode) |-> !ack_irq); // R4

  AST_GATED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(print_en) |-> !busy_irq); // R5
endmodule

// File: tb/lpt_strobe_ctrl_tb.sv
module lpt_strobe_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, prn_data;
  logic       print_en = 1'b1, alt_mode = 1'b0;
  logic       joy1_en = 1'b0, joy2_en = 1'b0, joy2_fire = 1'b0;
  logic [3:0] joy1_bits = '0, joy2_bits = '0;
  logic       prn_valid, busy_irq, ack_irq, drv_a_led, drv_b_led;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model
  logic [7:0] m_a = 8'hFF, m_b = 8'h00, m_pdata = 8'h00;
  logic       m_prev = 1'b0, m_valid = 1'b0, m_ack = 1'b0;

  always #4 clk = ~clk;

  lpt_strobe_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .print_en(print_en), .alt_mode(alt_mode),
    .joy1_en(joy1_en), .joy1_bits(joy1_bits),
    .joy2_en(joy2_en), .joy2_bits(joy2_bits), .joy2_fire(joy2_fire),
    .prn_data(prn_data), .prn_valid(prn_valid), .busy_irq(busy_irq),
    .ack_irq(ack_irq), .drv_a_led(drv_a_led), .drv_b_led(drv_b_led)
  );

  function automatic logic [7:0] exp_read();
    logic [7:0] v;
    if (rd_sel) begin
      v = m_b;
      if (joy1_en) v[7:4] = ~joy1_bits;
      if (joy2_en) v[3:0] = ~joy2_bits;
    end else begin
      v = m_a;
      if (joy2_en) v[5] = ~joy2_fire;
    end
    return v;
  endfunction

  function automatic string read_tag();
    if (!rd_sel && joy2_en) return "R11";
    if (rd_sel && joy1_en)  return "R9";
    if (rd_sel && joy2_en)  return "R10";
    return "R12";
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string xtag);
    chk(xtag, {7'd0, prn_valid}, {7'd0, m_valid});
    chk(xtag, {7'd0, busy_irq},  {7'd0, m_valid});
    chk("R4", {7'd0, ack_irq},   {7'd0, m_ack});
    chk(m_valid ? "R2" : "R7", prn_data, m_pdata);
    chk("R8", {6'd0, drv_b_led, drv_a_led}, {6'd0, ~m_a[2], ~m_a[1]});
    chk(read_tag(), rd_data, exp_read());
  endtask

  // op: 0 idle, 1 write A, 2 write B
  task automatic step(input int op, input logic [7:0] d, input string xtag);
    logic fire;
    @(negedge clk);
    wr_en   = (op != 0);
    wr_sel  = (op == 2);
    wr_data = d;
    fire = (op == 1) && m_prev && !d[5] && print_en;
    m_valid = fire;
    m_ack   = fire && alt_mode;
    if (fire) m_pdata = m_b;
    if (op == 1) begin m_a = d; m_prev = d[5]; end
    if (op == 2) m_b = d;
    @(posedge clk);
    #2;
    wr_en = 1'b0;
    check_all(xtag);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #2;
    check_all("R1");
    rd_sel = 1'b1; #1;
    chk("R1", rd_data, 8'h00);
    rd_sel = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check_all("R1");

    // R6: first low strobe after reset must not fire
    step(2, 8'h5A, "R3");
    step(1, 8'h00, "R6");
    // R3: rise, stay high, then B write
    step(1, 8'h20, "R3");
    step(1, 8'h26, "R3");
    step(2, 8'hC3, "R3");
    // R2: fall, then R7 hold
    step(1, 8'h04, "R2");
    step(0, 8'h00, "R7");
    step(1, 8'h00, "R3");   // low to low
    // R4: alt mode ack
    alt_mode = 1'b1;
    step(1, 8'h20, "R3");
    step(2, 8'h99, "R3");
    step(1, 8'h02, "R4");
    alt_mode = 1'b0;
    // R5: gated fall, history still updates
    step(1, 8'h20, "R3");
    print_en = 1'b0;
    step(1, 8'h00, "R5");
    print_en = 1'b1;
    step(1, 8'h00, "R5");
    // joystick reads
    joy1_en = 1'b1; joy1_bits = 4'h3; rd_sel = 1'b1;
    step(0, 8'h00, "R7");
    joy2_en = 1'b1; joy2_bits = 4'hA;
    step(0, 8'h00, "R7");
    rd_sel = 1'b0; joy2_fire = 1'b1;
    step(1, 8'hFF, "R3");
    joy2_fire = 1'b0;
    step(0, 8'h00, "R7");
    joy1_en = 1'b0; joy2_en = 1'b0;

    // random phase
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] d;
      op = $urandom % 3;
      d  = 8'($urandom);
      if (($urandom % 2) == 1) d[5] = ~m_prev;
      print_en  = ($urandom % 5) != 0;
      alt_mode  = 1'($urandom);
      joy1_en   = 1'($urandom);
      joy2_en   = 1'($urandom);
      joy1_bits = 4'($urandom);
      joy2_bits = 4'($urandom);
      joy2_fire = 1'($urandom);
      rd_sel    = 1'($urandom);
      step(op, d, (op == 1 && m_prev && !d[5]) ? "R2" : "R3");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule